// File: doc/BRIEF.md
# Dual-Channel Latched Converter Front End

This block is the synchronous digital front end of a two-channel 8-bit converter. A single 8-bit data port feeds two holding latches. A channel-select line picks the latch. Two active-low strobes, one for chip enable and one for write, gate each update. While both strobes are low, the chosen latch follows the data port on every clock. When either strobe returns high, the latch keeps the last byte it took.

A small memory-mapped path runs alongside the pin-level strobes. A CPU write to the base address loads channel A. A write to the next address loads channel B. Two bus writes on consecutive cycles therefore set both channels.

For each channel the block outputs the held code. It also outputs a signed value that a real converter would produce from that code and a signed reference input. Each channel has its own mode bit, which selects either straight unipolar or offset-binary bipolar scaling.

Top module: `dacfe_dual`

## Requirements
- R1: While `rst_n` is low, both held codes are 0x00 and both values are 0. This remains true after `rst_n` is released, until the first write.
- R2: With `bus_we` low, `chan_sel` low, `cs_n` low and `wr_n` low at a rising clock edge, `code_a` takes `din` after that edge, and `code_b` is unchanged.
- R3: With `bus_we` low, `chan_sel` high, `cs_n` low and `wr_n` low at a rising clock edge, `code_b` takes `din` after that edge, and `code_a` is unchanged.
- R4: With `bus_we` low and either `cs_n` or `wr_n` high, both held codes stay unchanged, whatever the values of `chan_sel` and `din`.
- R5: While the strobes stay low on consecutive clocks, the selected code follows `din` every cycle, one clock behind it.
- R6: After a strobe rises, the selected code keeps the `din` value sampled at the last edge on which both strobes were low.
- R7: When `bus_we` is high, the bus alone decides the update and the pin strobes are ignored. Address `BASE_ADDR` loads `code_a` with `bus_wdata`, and `BASE_ADDR+1` loads `code_b`. Any other address changes neither code. Back-to-back writes to the two addresses set both codes.
- R8: In mode 0 (unipolar), the value equals `-(vref*code)`. One value LSB is 1/256 of the reference, so code 0 gives 0.
- R9: In mode 1 (offset-binary bipolar), the value equals `vref*(2*code-256)` in the same 1/256 units, so code 0x80 gives 0.
- R10: Each channel's value depends only on its own code, its own mode bit and `vref`. It is combinational, so a change of mode or reference shows in the same cycle, without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 1 | Pin path channel choice: 0 selects A, 1 selects B |
| cs_n | input | 1 | Active-low chip enable strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Shared data port; bit 7 is the MSB |
| bus_we | input | 1 | Bus write enable; when high it overrides the pin strobes |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| vref | input | 16 | Signed reference value |
| mode_a | input | 1 | Channel A scaling: 0 unipolar, 1 bipolar |
| mode_b | input | 1 | Channel B scaling: 0 unipolar, 1 bipolar |
| code_a | output | 8 | Held code of channel A |
| code_b | output | 8 | Held code of channel B |
| val_a | output | 25 | Signed value of channel A in units of vref/256 |
| val_b | output | 25 | Signed value of channel B in units of vref/256 |

## Verification
A held code moves exactly one clock after the edge on which a strobe or bus write was sampled. The values follow their code, mode and reference with no further delay. The driver sets every input on the falling edge and queues the codes and values it expects after the next rising edge. The monitor compares each queued item just after that rising edge, so every check lands one cycle after its stimulus. This covers mode and reference changes too, which are applied with the same timing.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic {
    CONV_UNI = 1'b0,
    CONV_BIP = 1'b1
  } conv_e;

  localparam int unsigned NCH = 2;
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CODE_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040
) (
  input  logic              chan_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] din,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CODE_W-1:0] bus_wdata,
  output logic [1:0]        load,
  output logic [CODE_W-1:0] wdata
);
  localparam logic [ADDR_W-1:0] ADDR_B = BASE_ADDR + ADDR_W'(1);

  logic pin_write;
  assign pin_write = !cs_n && !wr_n;

  always_comb begin
    if (bus_we) begin
      load[0] = (bus_addr == BASE_ADDR);
      load[1] = (bus_addr == ADDR_B);
      wdata   = bus_wdata;
    end else begin
      load[0] = pin_write && !chan_sel;
      load[1] = pin_write && chan_sel;
      wdata   = din;
    end
  end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else if (load) code <= wdata;
  end

  // R5
  follow_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (code == $past(wdata)));

  // R6
  hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code));
endmodule

// File: rtl/dacfe_map.sv
module dacfe_map
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VREF_W = 16,
  parameter int unsigned OUT_W  = VREF_W + CODE_W + 1
) (
  input  conv_e                    mode,
  input  logic signed [VREF_W-1:0] vref,
  input  logic [CODE_W-1:0]        code,
  output logic signed [OUT_W-1:0]  val
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  function automatic logic signed [OUT_W-1:0] uni_val(
    input logic signed [VREF_W-1:0] r,
    input logic [CODE_W-1:0] c
  );
    logic signed [OUT_W-1:0] rr;
    logic signed [OUT_W-1:0] cc;
    rr = OUT_W'(r);
    cc = $signed(OUT_W'(c));
    return -(rr * cc);
  endfunction

  function automatic logic signed [OUT_W-1:0] bip_val(
    input logic signed [VREF_W-1:0] r,
    input logic [CODE_W-1:0] c
  );
    logic signed [OUT_W-1:0] rr;
    logic signed [OUT_W-1:0] cc;
    rr = OUT_W'(r);
    cc = ($signed(OUT_W'(c)) <<< 1) - $signed(OUT_W'(1) << CODE_W);
    return rr * cc;
  endfunction

  always_comb begin
    if (mode == CONV_BIP) val = bip_val(vref, code);
    else                  val = uni_val(vref, code);
  end

  always_comb begin
    // R9
    if (mode == CONV_BIP && code == MID_CODE)
      bip_mid_zero_chk: assert (val == '0);
    // R8
    if (mode == CONV_UNI && code == '0)
      uni_zero_chk: assert (val == '0);
  end
endmodule

// File: rtl/dacfe_dual.sv
module dacfe_dual
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VREF_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter int unsigned OUT_W  = VREF_W + CODE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chan_sel,
  input  logic                     cs_n,
  input  logic                     wr_n,
  input  logic [CODE_W-1:0]        din,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [CODE_W-1:0]        bus_wdata,
  input  logic signed [VREF_W-1:0] vref,
  input  logic                     mode_a,
  input  logic                     mode_b,
  output logic [CODE_W-1:0]        code_a,
  output logic [CODE_W-1:0]        code_b,
  output logic signed [OUT_W-1:0]  val_a,
  output logic signed [OUT_W-1:0]  val_b
);
  logic [1:0]               load;
  logic [CODE_W-1:0]        wdata;
  logic [CODE_W-1:0]        code_v [NCH];
  logic signed [OUT_W-1:0]  val_v  [NCH];
  conv_e                    mode_v [NCH];

  assign mode_v[0] = conv_e'(mode_a);
  assign mode_v[1] = conv_e'(mode_b);

  dacfe_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .chan_sel(chan_sel), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .load(load), .wdata(wdata)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dacfe_latch #(.CODE_W(CODE_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .load(load[ch]), .wdata(wdata), .code(code_v[ch])
    );
    dacfe_map #(.CODE_W(CODE_W), .VREF_W(VREF_W), .OUT_W(OUT_W)) u_map (
      .mode(mode_v[ch]), .vref(vref), .code(code_v[ch]), .val(val_v[ch])
    );
  end

  assign code_a = code_v[0];
  assign code_b = code_v[1];
  assign val_a  = val_v[0];
  assign val_b  = val_v[1];

  // R2
  pin_write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !cs_n && !wr_n && !chan_sel) |=> (code_a == $past(din)) && $stable(code_b));

  // R3
  pin_write_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !cs_n && !wr_n && chan_sel) |=> (code_b == $past(din)) && $stable(code_a));

  // R4
  strobe_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && (cs_n || wr_n)) |=> $stable(code_a) && $stable(code_b));

  // R7
  bus_write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BASE_ADDR) |=> (code_a == $past(bus_wdata)) && $stable(code_b));
endmodule

// File: tb/dacfe_dual_test.sv
`timescale 1ns/1ps
module dacfe_dual_test;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned VREF_W = 16;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'h0040;
  localparam int unsigned OUT_W = VREF_W + CODE_W + 1;

  typedef struct {
    logic [7:0] ca;
    logic [7:0] cb;
    longint     va;
    longint     vb;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_sel = 1'b0, cs_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic signed [VREF_W-1:0] vref = 16'sd1000;
  logic mode_a = 1'b0, mode_b = 1'b0;
  logic [7:0] code_a, code_b;
  logic signed [OUT_W-1:0] val_a, val_b;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [7:0] ref_a = '0, ref_b = '0;

  always #2.5 clk = ~clk;

  dacfe_dual uut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .vref(vref),
    .mode_a(mode_a), .mode_b(mode_b), .code_a(code_a), .code_b(code_b),
    .val_a(val_a), .val_b(val_b)
  );

  function automatic longint model_val(input logic m, input longint r, input logic [7:0] c);
    longint d = longint'(c);
    if (m) return 2 * r * d - 256 * r;
    return -(r * d);
  endfunction

  task automatic compare(input exp_t e);
    longint aa = longint'(val_a);
    longint ab = longint'(val_b);
    vectors++;
    if (code_a !== e.ca || code_b !== e.cb || aa != e.va || ab != e.vb) begin
      errors++;
      $display("FAIL %s: got a=%02h/%0d b=%02h/%0d expected a=%02h/%0d b=%02h/%0d",
               e.tag, code_a, aa, code_b, ab, e.ca, e.va, e.cb, e.vb);
    end
  endtask

  // Driver: sets inputs on the falling edge, updates its model, queues the expected result
  task automatic step(input logic s, input logic c, input logic w, input logic [7:0] d,
                      input logic bwe, input logic [ADDR_W-1:0] ba, input logic [7:0] bd,
                      input logic signed [VREF_W-1:0] r, input logic ma, input logic mb,
                      input string tag);
    exp_t e;
    @(negedge clk);
    chan_sel = s; cs_n = c; wr_n = w; din = d;
    bus_we = bwe; bus_addr = ba; bus_wdata = bd;
    vref = r; mode_a = ma; mode_b = mb;
    if (bwe) begin
      if (ba == BASE) ref_a = bd;
      else if (ba == BASE + 16'd1) ref_b = bd;
    end else if (!c && !w) begin
      if (s) ref_b = d; else ref_a = d;
    end
    e.ca = ref_a; e.cb = ref_b;
    e.va = model_val(ma, longint'(r), ref_a);
    e.vb = model_val(mb, longint'(r), ref_b);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic pin(input logic s, input logic c, input logic w, input logic [7:0] d, input string tag);
    step(s, c, w, d, 1'b0, '0, '0, vref, mode_a, mode_b, tag);
  endtask

  task automatic bus(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, a, d, vref, mode_a, mode_b, tag);
  endtask

  task automatic ana(input logic signed [VREF_W-1:0] r, input logic ma, input logic mb, input string tag);
    step(1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, '0, '0, r, ma, mb, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // Monitor: compares one queued item just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while reset is held
    e0.ca = 8'h00; e0.cb = 8'h00; e0.va = 0; e0.vb = 0; e0.tag = "R1 during reset";
    compare(e0);
    @(negedge clk);
    rst_n = 1'b1;
    pin(1'b0, 1'b1, 1'b1, 8'hFF, "R1 after release");

    // R2 / R3: one channel written, the other holds
    pin(1'b0, 1'b0, 1'b0, 8'h5A, "R2 write A");
    pin(1'b1, 1'b0, 1'b0, 8'hC3, "R3 write B");

    // R4: either strobe high holds both
    pin(1'b0, 1'b1, 1'b0, 8'hFF, "R4 cs_n high sel A");
    pin(1'b1, 1'b0, 1'b1, 8'h11, "R4 wr_n high sel B");
    pin(1'b1, 1'b1, 1'b1, 8'h22, "R4 both high");

    // R5: transparency over consecutive cycles
    pin(1'b0, 1'b0, 1'b0, 8'h10, "R5 follow 1");
    pin(1'b0, 1'b0, 1'b0, 8'h20, "R5 follow 2");
    pin(1'b0, 1'b0, 1'b0, 8'h30, "R5 follow 3");

    // R6: release keeps last sampled byte
    pin(1'b0, 1'b0, 1'b1, 8'h99, "R6 wr_n release");
    pin(1'b0, 1'b0, 1'b1, 8'h77, "R6 still held");
    pin(1'b1, 1'b0, 1'b0, 8'h44, "R5 follow B");
    pin(1'b1, 1'b1, 1'b0, 8'h55, "R6 cs_n release B");

    // R7: bus path
    bus(BASE, 8'h80, "R7 bus A");
    bus(BASE + 16'd1, 8'h01, "R7 bus B back to back");
    bus(BASE + 16'd2, 8'hEE, "R7 out of window");
    bus(BASE - 16'd1, 8'hEF, "R7 below window");
    step(1'b0, 1'b0, 1'b0, 8'h77, 1'b1, BASE + 16'd1, 8'h6B, vref, mode_a, mode_b,
         "R7 bus overrides pins");

    // R8 / R9 / R10: scaling under several references and modes
    ana(16'sd1000, 1'b0, 1'b1, "R10 modes split");
    ana(-16'sd32768, 1'b1, 1'b0, "R10 vref min swap");
    ana(16'sd32767, 1'b1, 1'b1, "R9 vref max");
    for (int k = 0; k < 6; k++) begin
      logic [7:0] cv;
      case (k)
        0: cv = 8'h00; 1: cv = 8'hFF; 2: cv = 8'h80;
        3: cv = 8'h7F; 4: cv = 8'h01; default: cv = 8'h81;
      endcase
      pin(1'b0, 1'b0, 1'b0, cv, "R8 unipolar A");
      ana(-16'sd32768, 1'b0, 1'b1, "R8 unipolar A min ref");
      ana(16'sd32767, 1'b1, 1'b1, "R9 bipolar A max ref");
      ana(-16'sd1234, 1'b1, 1'b0, "R9 bipolar A neg ref");
      pin(1'b1, 1'b0, 1'b0, ~cv, "R3 write B for scaling");
      ana(16'sd777, 1'b0, 1'b1, "R10 independent modes");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule